// File: doc/BRIEF.md
# Helper-Thread Branch Prediction Correlator

This block sits in the fetch stage beside the default branch predictor. It ties branch directions computed early by helper threads to particular dynamic executions of hard-to-predict branches in the main thread. Each tracked branch has a small ring of per-iteration prediction slots. A slot is reserved when the helper's prediction-producing instruction is fetched, and it is filled when that instruction executes. When the main thread fetches the tracked branch, the oldest live slot decides whether the block's direction replaces the default one.

A slot is not used up when a branch reads it. It goes away only when the main thread's fetch path shows it can no longer be used. Fetch of a per-entry loop-iteration address kills the oldest live slot. Fetch of a per-entry slice-exit address kills every live slot. A kill is only a mark. It is undone when the killing instruction is squashed, and it becomes final when that instruction retires. If an outcome arrives after the branch has already used the default direction, and the two differ while the branch is still unresolved, the block asks for a fetch redirect.

Top module: `hpc_pred_correlator`

## Requirements
- R1: After reset, and for any fetch address that matches no configured entry, `pred_override` is 0, `pred_dir` equals `fetch_def_dir`, and `rd_valid` is 0.
- R2: A reservation on a configured entry returns `al_ok`=1 and a slot index that counts up modulo 8 around that entry's ring. When 8 slots are in use, `al_ok` is 0 and nothing is reserved. An outcome sent to a slot that is neither Empty nor Late is ignored.
- R3: If the oldest live slot of the fetched branch is Full, `pred_override` is 1 and `pred_dir` is the stored direction, in the same cycle as the fetch.
- R4: If that slot is Empty, the default direction is passed through with `pred_override`=0. The slot becomes Late and records the fetch sequence number and the direction used.
- R5: An outcome for a Late slot fills it. If the outcome differs from the recorded direction and no `res_valid` has named the consumer's sequence number, `rd_valid` pulses one cycle later with `rd_seq`=consumer sequence and `rd_dir`=outcome. Otherwise there is no pulse.
- R6: Fetch of the loop-kill address marks the oldest live slot killed. Killed slots are skipped when the next oldest live slot is chosen.
- R7: Fetch of the slice-kill address marks every live slot of that entry killed, whether Empty or Full. A following branch fetch gets the default.
- R8: A killed slot is freed when `ret_seq` equals its killer sequence, which returns ring capacity. A squash clears the killed mark of every slot whose killer sequence is at or younger than `sq_seq`.
- R9: When an entry is configured with its loop-kill address being the loop back-edge target, the first loop-kill fetch after a fork of that entry kills nothing. Later loop-kill fetches kill normally.
- R10: Age comparison for squash uses wrap-around arithmetic: a is at or younger than b when bit SW-1 of (a - b) is 0.
- R11: If an outcome for the chosen Empty slot arrives in the same cycle as the branch fetch, the outcome is forwarded: `pred_override`=1, `pred_dir`=outcome, and the slot becomes Full with no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | IW | Entry to write |
| cfg_valid | input | 1 | Entry enabled |
| cfg_br_pc | input | AW | Tracked branch address |
| cfg_lk_pc | input | AW | Loop-iteration kill address |
| cfg_sk_pc | input | AW | Slice-exit kill address |
| cfg_lk_backedge | input | 1 | Loop-kill address is the back-edge target |
| fork_valid | input | 1 | Helper slice forked |
| fork_idx | input | IW | Entry of the forked slice |
| al_valid | input | 1 | Prediction producer fetched |
| al_br | input | IW | Entry it predicts for |
| al_ok | output | 1 | Slot reserved |
| al_slot | output | PW | Reserved slot index |
| ex_valid | input | 1 | Prediction producer executed |
| ex_br | input | IW | Entry of the outcome |
| ex_slot | input | PW | Slot of the outcome |
| ex_dir | input | 1 | Computed direction |
| fetch_valid | input | 1 | Main-thread fetch |
| fetch_pc | input | AW | Fetched address |
| fetch_seq | input | SW | Fetched instruction sequence number |
| fetch_def_dir | input | 1 | Default predictor direction |
| pred_override | output | 1 | Block direction replaces default |
| pred_dir | output | 1 | Final direction |
| res_valid | input | 1 | Branch resolved |
| res_seq | input | SW | Resolved branch sequence |
| ret_valid | input | 1 | Instruction retired |
| ret_seq | input | SW | Retired sequence |
| sq_valid | input | 1 | Squash |
| sq_seq | input | SW | Oldest squashed sequence |
| rd_valid | output | 1 | Late outcome disagrees: redirect |
| rd_seq | output | SW | Branch to reverse |
| rd_dir | output | 1 | Corrected direction |

## Verification
Two functions can land in the same cycle: the branch fetch that selects an Empty slot, and the execution outcome for that same slot. The bench drives both in one cycle. It expects the outcome to be forwarded to `pred_dir` with the override set, and no redirect in the next cycle. A later fetch must still see the slot as Full. The bench also squashes around the 8-bit sequence wrap point to show that killed marks come back only for killers that are younger by modular distance.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
   typedef enum logic [1:0] {
      SL_INV   = 2'd0,
      SL_EMPTY = 2'd1,
      SL_FULL  = 2'd2,
      SL_LATE  = 2'd3
   } slot_st_e;
endpackage

// File: rtl/hpc_cam_match.sv
module hpc_cam_match #(
   parameter int N  = 64,
   parameter int AW = 32,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]         en,
   input  logic [N-1:0][AW-1:0] keys,
   input  logic [AW-1:0]        probe,
   output logic                 hit,
   output logic [IW-1:0]        idx
);
   // lowest matching entry wins
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (en[i] && keys[i] == probe) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/hpc_oldest_pick.sv
module hpc_oldest_pick #(
   parameter int NS = 8,
   localparam int PW = $clog2(NS)
) (
   input  logic [NS-1:0] live,
   input  logic [PW-1:0] head,
   output logic          found,
   output logic [PW-1:0] idx
);
   logic [PW-1:0] pos;
   // scan from the ring head; the nearest live slot is the oldest
   always_comb begin
      found = 1'b0;
      idx   = head;
      pos   = head;
      for (int k = NS-1; k >= 0; k--) begin
         pos = head + PW'(k);
         if (live[pos]) begin
            found = 1'b1;
            idx   = pos;
         end
      end
   end
endmodule

// File: rtl/hpc_pred_correlator.sv
module hpc_pred_correlator
   import hpc_pkg::*;
#(
   parameter int N_BR   = 64,
   parameter int N_SLOT = 8,
   parameter int AW     = 32,
   parameter int SW     = 8,
   localparam int IW = $clog2(N_BR),
   localparam int PW = $clog2(N_SLOT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [IW-1:0] cfg_idx,
   input  logic          cfg_valid,
   input  logic [AW-1:0] cfg_br_pc,
   input  logic [AW-1:0] cfg_lk_pc,
   input  logic [AW-1:0] cfg_sk_pc,
   input  logic          cfg_lk_backedge,
   input  logic          fork_valid,
   input  logic [IW-1:0] fork_idx,
   input  logic          al_valid,
   input  logic [IW-1:0] al_br,
   output logic          al_ok,
   output logic [PW-1:0] al_slot,
   input  logic          ex_valid,
   input  logic [IW-1:0] ex_br,
   input  logic [PW-1:0] ex_slot,
   input  logic          ex_dir,
   input  logic          fetch_valid,
   input  logic [AW-1:0] fetch_pc,
   input  logic [SW-1:0] fetch_seq,
   input  logic          fetch_def_dir,
   output logic          pred_override,
   output logic          pred_dir,
   input  logic          res_valid,
   input  logic [SW-1:0] res_seq,
   input  logic          ret_valid,
   input  logic [SW-1:0] ret_seq,
   input  logic          sq_valid,
   input  logic [SW-1:0] sq_seq,
   output logic          rd_valid,
   output logic [SW-1:0] rd_seq,
   output logic          rd_dir
);
   localparam int CW = PW + 1;

   initial begin
      assert (N_SLOT >= 2 && N_SLOT == (1 << PW))
         else $error("N_SLOT must be a power of two >= 2");
      assert (N_BR >= 2 && SW >= 2)
         else $error("N_BR and SW must be at least 2");
   end

   function automatic logic at_or_younger(input logic [SW-1:0] a, input logic [SW-1:0] b);
      logic [SW-1:0] d;
      d = a - b;
      return !d[SW-1];
   endfunction

   // entry table
   logic [N_BR-1:0]         ent_v, lk_be, skip_lk;
   logic [N_BR-1:0][AW-1:0] br_pc, lk_pc, sk_pc;
   logic [CW-1:0]           head [N_BR];
   logic [CW-1:0]           tail [N_BR];

   // slot state
   slot_st_e      st   [N_BR][N_SLOT];
   logic          sdir [N_BR][N_SLOT];
   logic          kld  [N_BR][N_SLOT];
   logic          pend [N_BR][N_SLOT];
   logic [SW-1:0] cons [N_BR][N_SLOT];
   logic [SW-1:0] kseq [N_BR][N_SLOT];

   logic [N_SLOT-1:0] live [N_BR];
   always_comb begin
      for (int e = 0; e < N_BR; e++)
         for (int s = 0; s < N_SLOT; s++)
            live[e][s] = (st[e][s] != SL_INV) && !kld[e][s];
   end

   // address match
   logic          br_hit, lk_hit, sk_hit;
   logic [IW-1:0] br_i, lk_i, sk_i;

   hpc_cam_match #(.N(N_BR), .AW(AW)) u_cam_br (
      .en(ent_v), .keys(br_pc), .probe(fetch_pc), .hit(br_hit), .idx(br_i));
   hpc_cam_match #(.N(N_BR), .AW(AW)) u_cam_lk (
      .en(ent_v), .keys(lk_pc), .probe(fetch_pc), .hit(lk_hit), .idx(lk_i));
   hpc_cam_match #(.N(N_BR), .AW(AW)) u_cam_sk (
      .en(ent_v), .keys(sk_pc), .probe(fetch_pc), .hit(sk_hit), .idx(sk_i));

   // oldest live slot of the branch entry and of the loop-kill entry
   logic          bo_found, ko_found;
   logic [PW-1:0] bo, ko;

   hpc_oldest_pick #(.NS(N_SLOT)) u_pick_br (
      .live(live[br_i]), .head(head[br_i][PW-1:0]), .found(bo_found), .idx(bo));
   hpc_oldest_pick #(.NS(N_SLOT)) u_pick_lk (
      .live(live[lk_i]), .head(head[lk_i][PW-1:0]), .found(ko_found), .idx(ko));

   // fetch-side decision
   logic     br_use, fwd;
   slot_st_e bo_st;
   always_comb begin
      br_use = fetch_valid && br_hit && bo_found;
      bo_st  = st[br_i][bo];
      fwd    = br_use && bo_st == SL_EMPTY && ex_valid && ex_br == br_i && ex_slot == bo;
      pred_override = br_use && (bo_st == SL_FULL || fwd);
      if (fwd)
         pred_dir = ex_dir;
      else if (pred_override)
         pred_dir = sdir[br_i][bo];
      else
         pred_dir = fetch_def_dir;
   end

   // reservation
   logic [CW-1:0] al_cnt;
   always_comb begin
      al_cnt  = tail[al_br] - head[al_br];
      al_ok   = al_valid && ent_v[al_br] && al_cnt != CW'(N_SLOT);
      al_slot = tail[al_br][PW-1:0];
   end

   slot_st_e ex_st;
   assign ex_st = st[ex_br][ex_slot];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_v    <= '0;
         lk_be    <= '0;
         skip_lk  <= '0;
         rd_valid <= 1'b0;
         rd_seq   <= '0;
         rd_dir   <= 1'b0;
         for (int e = 0; e < N_BR; e++) begin
            head[e] <= '0;
            tail[e] <= '0;
            for (int s = 0; s < N_SLOT; s++) begin
               st[e][s]   <= SL_INV;
               kld[e][s]  <= 1'b0;
               pend[e][s] <= 1'b0;
            end
         end
      end else begin
         rd_valid <= 1'b0;

         // ring head walks past freed slots, one per cycle
         for (int e = 0; e < N_BR; e++)
            if (tail[e] != head[e] && st[e][head[e][PW-1:0]] == SL_INV)
               head[e] <= head[e] + CW'(1);

         if (cfg_we) begin
            ent_v[cfg_idx]   <= cfg_valid;
            br_pc[cfg_idx]   <= cfg_br_pc;
            lk_pc[cfg_idx]   <= cfg_lk_pc;
            sk_pc[cfg_idx]   <= cfg_sk_pc;
            lk_be[cfg_idx]   <= cfg_lk_backedge;
            skip_lk[cfg_idx] <= 1'b0;
            head[cfg_idx]    <= '0;
            tail[cfg_idx]    <= '0;
            for (int s = 0; s < N_SLOT; s++) begin
               st[cfg_idx][s]  <= SL_INV;
               kld[cfg_idx][s] <= 1'b0;
            end
         end

         if (fork_valid)
            skip_lk[fork_idx] <= lk_be[fork_idx];

         if (al_ok) begin
            st[al_br][al_slot]   <= SL_EMPTY;
            kld[al_br][al_slot]  <= 1'b0;
            pend[al_br][al_slot] <= 1'b0;
            tail[al_br]          <= tail[al_br] + CW'(1);
         end

         // outcome delivery
         if (ex_valid && (ex_st == SL_EMPTY || ex_st == SL_LATE)) begin
            st[ex_br][ex_slot]   <= SL_FULL;
            sdir[ex_br][ex_slot] <= ex_dir;
            pend[ex_br][ex_slot] <= 1'b0;
            if (ex_st == SL_LATE && pend[ex_br][ex_slot] && sdir[ex_br][ex_slot] != ex_dir) begin
               rd_valid <= 1'b1;
               rd_seq   <= cons[ex_br][ex_slot];
               rd_dir   <= ex_dir;
            end
         end

         // tracked branch fetched
         if (br_use) begin
            cons[br_i][bo] <= fetch_seq;
            if (bo_st == SL_EMPTY && !fwd) begin
               st[br_i][bo]   <= SL_LATE;
               sdir[br_i][bo] <= fetch_def_dir;
               pend[br_i][bo] <= 1'b1;
            end
         end

         // loop-iteration kill
         if (fetch_valid && lk_hit) begin
            if (skip_lk[lk_i])
               skip_lk[lk_i] <= 1'b0;
            else if (ko_found) begin
               kld[lk_i][ko]  <= 1'b1;
               kseq[lk_i][ko] <= fetch_seq;
            end
         end

         // slice-exit kill
         if (fetch_valid && sk_hit)
            for (int s = 0; s < N_SLOT; s++)
               if (live[sk_i][s]) begin
                  kld[sk_i][s]  <= 1'b1;
                  kseq[sk_i][s] <= fetch_seq;
               end

         for (int e = 0; e < N_BR; e++)
            for (int s = 0; s < N_SLOT; s++) begin
               if (res_valid && st[e][s] == SL_LATE && cons[e][s] == res_seq)
                  pend[e][s] <= 1'b0;
               if (sq_valid && kld[e][s] && at_or_younger(kseq[e][s], sq_seq))
                  kld[e][s] <= 1'b0;
               if (sq_valid && st[e][s] == SL_LATE && at_or_younger(cons[e][s], sq_seq)) begin
                  st[e][s]   <= SL_EMPTY;
                  pend[e][s] <= 1'b0;
               end
               if (ret_valid && kld[e][s] && kseq[e][s] == ret_seq) begin
                  st[e][s]  <= SL_INV;
                  kld[e][s] <= 1'b0;
               end
            end
      end
   end

   // R5: a redirect is always caused by an outcome one cycle earlier
   a_r5_redirect_follows_exec: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(ex_valid));
   // R5: the corrected direction is the delivered outcome
   a_r5_redirect_dir: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_dir == $past(ex_dir));
   // R3: an override only appears during a fetch
   a_r3_override_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      pred_override |-> fetch_valid);
   // R4: without an override the default direction passes through
   a_r4_default_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !pred_override) |-> pred_dir == fetch_def_dir);
   // R2: a slot is reserved only on request
   a_r2_alloc_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      al_ok |-> al_valid);
endmodule

// File: tb/test_hpc_pred_correlator.sv
module test_hpc_pred_correlator;
   localparam int IW = 6, PW = 3, AW = 32, SW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          cfg_we, cfg_valid, cfg_lk_backedge;
   logic [IW-1:0] cfg_idx;
   logic [AW-1:0] cfg_br_pc, cfg_lk_pc, cfg_sk_pc;
   logic          fork_valid;
   logic [IW-1:0] fork_idx;
   logic          al_valid, al_ok;
   logic [IW-1:0] al_br;
   logic [PW-1:0] al_slot;
   logic          ex_valid, ex_dir;
   logic [IW-1:0] ex_br;
   logic [PW-1:0] ex_slot;
   logic          fetch_valid, fetch_def_dir, pred_override, pred_dir;
   logic [AW-1:0] fetch_pc;
   logic [SW-1:0] fetch_seq;
   logic          res_valid, ret_valid, sq_valid;
   logic [SW-1:0] res_seq, ret_seq, sq_seq;
   logic          rd_valid, rd_dir;
   logic [SW-1:0] rd_seq;

   hpc_pred_correlator i_hpc_pred_correlator (
      .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_valid, .cfg_br_pc, .cfg_lk_pc, .cfg_sk_pc,
      .cfg_lk_backedge, .fork_valid, .fork_idx, .al_valid, .al_br, .al_ok, .al_slot,
      .ex_valid, .ex_br, .ex_slot, .ex_dir, .fetch_valid, .fetch_pc, .fetch_seq,
      .fetch_def_dir, .pred_override, .pred_dir, .res_valid, .res_seq, .ret_valid,
      .ret_seq, .sq_valid, .sq_seq, .rd_valid, .rd_seq, .rd_dir);

   int n_chk = 0;
   int n_err = 0;

   typedef struct {
      logic  ovr;
      logic  dir;
      string req;
   } exp_t;
   exp_t expq[$];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   task automatic idle();
      cfg_we = 0; cfg_valid = 0; cfg_lk_backedge = 0; cfg_idx = '0;
      cfg_br_pc = '0; cfg_lk_pc = '0; cfg_sk_pc = '0;
      fork_valid = 0; fork_idx = '0;
      al_valid = 0; al_br = '0;
      ex_valid = 0; ex_br = '0; ex_slot = '0; ex_dir = 0;
      fetch_valid = 0; fetch_pc = '0; fetch_seq = '0; fetch_def_dir = 0;
      res_valid = 0; res_seq = '0; ret_valid = 0; ret_seq = '0;
      sq_valid = 0; sq_seq = '0;
   endtask

   task automatic finish_cycle();
      @(posedge clk);
      #1 idle();
   endtask

   // monitor: compares every fetch against the scoreboard
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (fetch_valid) begin
            if (expq.size() == 0)
               chk(1'b0, "scoreboard empty", 0, 1);
            else begin
               e = expq.pop_front();
               chk(pred_override == e.ovr && pred_dir == e.dir, e.req,
                   int'({pred_override, pred_dir}), int'({e.ovr, e.dir}));
            end
         end
      end
   end

   task automatic cfg(input int idx, input logic [AW-1:0] b, input logic [AW-1:0] l,
                      input logic [AW-1:0] s, input logic be);
      @(negedge clk);
      cfg_we = 1; cfg_valid = 1; cfg_idx = IW'(idx);
      cfg_br_pc = b; cfg_lk_pc = l; cfg_sk_pc = s; cfg_lk_backedge = be;
      finish_cycle();
   endtask

   task automatic fetch(input logic [AW-1:0] pc, input int seq, input logic def,
                        input logic eo, input logic ed, input string req);
      @(negedge clk);
      expq.push_back('{eo, ed, req});
      fetch_valid = 1; fetch_pc = pc; fetch_seq = SW'(seq); fetch_def_dir = def;
      finish_cycle();
   endtask

   task automatic alloc(input int br, input bit eok, input int eslot, input string req);
      @(negedge clk);
      al_valid = 1; al_br = IW'(br);
      #1 chk(al_ok == eok && (!eok || al_slot == PW'(eslot)), req,
             int'({al_ok, al_slot}), int'({eok, PW'(eslot)}));
      finish_cycle();
   endtask

   task automatic exec(input int br, input int slot, input logic d, input bit erd,
                       input int eseq, input string req);
      @(negedge clk);
      ex_valid = 1; ex_br = IW'(br); ex_slot = PW'(slot); ex_dir = d;
      finish_cycle();
      chk(rd_valid == erd && (!erd || (rd_seq == SW'(eseq) && rd_dir == d)), req,
          int'({rd_valid, rd_seq, rd_dir}), int'({erd, SW'(eseq), d}));
   endtask

   task automatic squash(input int seq);
      @(negedge clk);
      sq_valid = 1; sq_seq = SW'(seq);
      finish_cycle();
   endtask

   task automatic retire(input int seq);
      @(negedge clk);
      ret_valid = 1; ret_seq = SW'(seq);
      finish_cycle();
   endtask

   localparam logic [AW-1:0] B0 = 32'h100, L0 = 32'h200, S0 = 32'h300;
   localparam logic [AW-1:0] B1 = 32'h110, L1 = 32'h210, S1 = 32'h310;

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 chk(rd_valid == 1'b0, "R1 reset redirect", int'(rd_valid), 0);
      @(negedge clk);
      rst_n = 1;
      fetch(B0, 1, 1'b1, 1'b0, 1'b1, "R1 unconfigured default");
      chk(rd_valid == 1'b0, "R1 no redirect", int'(rd_valid), 0);

      cfg(0, B0, L0, S0, 1'b0);
      cfg(1, B1, L1, S1, 1'b1);

      alloc(0, 1, 0, "R2 slot 0");
      alloc(0, 1, 1, "R2 slot 1");
      alloc(0, 1, 2, "R2 slot 2");
      exec(0, 0, 1'b0, 0, 0, "R3 fill no redirect");
      exec(0, 1, 1'b1, 0, 0, "R3 fill no redirect");
      fetch(B0, 10, 1'b1, 1'b1, 1'b0, "R3 full overrides");
      fetch(L0, 11, 1'b0, 1'b0, 1'b0, "R6 kill fetch");
      fetch(B0, 12, 1'b0, 1'b1, 1'b1, "R6 killed slot skipped");
      fetch(L0, 13, 1'b0, 1'b0, 1'b0, "R6 kill fetch");
      fetch(B0, 14, 1'b1, 1'b0, 1'b1, "R4 empty uses default");
      exec(0, 2, 1'b0, 1, 14, "R5 late mismatch redirect");

      squash(13);
      fetch(B0, 13, 1'b0, 1'b1, 1'b1, "R8 squash restores kill");
      retire(11);
      repeat (2) @(posedge clk);
      alloc(0, 1, 3, "R8 freed slot returns capacity");
      alloc(0, 1, 4, "R2 ring order");
      alloc(0, 1, 5, "R2 ring order");
      alloc(0, 1, 6, "R2 ring order");
      alloc(0, 1, 7, "R2 ring order");
      alloc(0, 1, 0, "R2 ring wraps");
      alloc(0, 0, 0, "R2 ninth dropped");
      exec(0, 1, 1'b0, 0, 0, "R2 outcome to full ignored");
      fetch(B0, 15, 1'b0, 1'b1, 1'b1, "R2 ignored outcome kept dir");

      fetch(S0, 20, 1'b1, 1'b0, 1'b1, "R7 slice kill fetch");
      fetch(B0, 21, 1'b0, 1'b0, 1'b0, "R7 all killed default");
      retire(20);
      repeat (10) @(posedge clk);
      alloc(0, 1, 1, "R8 retire frees ring");

      fetch(B0, 22, 1'b1, 1'b0, 1'b1, "R4 late again");
      exec(0, 1, 1'b1, 0, 0, "R5 matching outcome no redirect");
      alloc(0, 1, 2, "R2 next slot");
      fetch(L0, 23, 1'b0, 1'b0, 1'b0, "R6 kill fetch");
      fetch(B0, 24, 1'b0, 1'b0, 1'b0, "R4 late with default 0");
      @(negedge clk);
      res_valid = 1; res_seq = 8'd24;
      finish_cycle();
      exec(0, 2, 1'b1, 0, 0, "R5 resolved no redirect");

      fetch(L0, 25, 1'b0, 1'b0, 1'b0, "R6 kill fetch");
      alloc(0, 1, 3, "R2 next slot");
      @(negedge clk);
      expq.push_back('{1'b1, 1'b1, "R11 same-cycle forward"});
      fetch_valid = 1; fetch_pc = B0; fetch_seq = 8'd26; fetch_def_dir = 0;
      ex_valid = 1; ex_br = '0; ex_slot = 3'd3; ex_dir = 1;
      finish_cycle();
      chk(rd_valid == 1'b0, "R11 forward no redirect", int'(rd_valid), 0);
      fetch(B0, 27, 1'b0, 1'b1, 1'b1, "R11 slot became full");

      @(negedge clk);
      fork_valid = 1; fork_idx = 6'd1;
      finish_cycle();
      alloc(1, 1, 0, "R2 entry1 slot 0");
      exec(1, 0, 1'b1, 0, 0, "R3 fill entry1");
      fetch(L1, 30, 1'b0, 1'b0, 1'b0, "R9 first kill skipped");
      fetch(B1, 31, 1'b0, 1'b1, 1'b1, "R9 prediction survives");
      fetch(L1, 32, 1'b0, 1'b0, 1'b0, "R9 second kill");
      fetch(B1, 33, 1'b0, 1'b0, 1'b0, "R9 second kill applied");
      squash(250);
      fetch(B1, 34, 1'b0, 1'b1, 1'b1, "R10 wrap squash restores");
      fetch(L1, 40, 1'b0, 1'b0, 1'b0, "R10 kill fetch");
      squash(41);
      fetch(B1, 42, 1'b0, 1'b0, 1'b0, "R10 older killer kept");

      repeat (2) @(posedge clk);
      chk(expq.size() == 0, "scoreboard drained", expq.size(), 0);
      summary();
      $finish;
   end
endmodule